// File: doc/BRIEF.md
# USB Serial Line Transmitter

This block turns a stream of bytes into full-speed or low-speed USB line signalling on a D+/D- pair. Software writes 9-bit words into a valid/ready port. A word with its top flag set opens a packet, and its byte (normally the sync pattern 0x80) is the first one shifted out. Each following byte waits in a one-byte holding register behind the byte on the wire. Bits leave least significant first. They are NRZI coded, and a zero is stuffed after every run of six ones.

Nothing has to be written to close a packet. If the holding register is empty when the transmitter needs its next bit, the block drives two bit times of SE0, one bit time of J, and then releases the pair. A 16-bit numerically controlled oscillator sets the bit period. Low speed divides the programmed increment by eight and swaps the J/K polarity. Software keeps a stream going by watching `wr_ready` or `buf_full`.

The write port has one back-pressure rule: a word is taken on a rising clock edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the holding register is occupied. Taken words that the block cannot use are dropped.

Top module: `usb_line_tx`

## Requirements
- R1: A word is accepted on a clock edge where wr_valid and wr_ready are both high. Bit 8 of wr_data flags a packet start. A start word accepted while idle begins a packet with its byte bits [7:0].
- R2: Line encoding when driven (usb_oe=1): SE0 is dp=0,dm=0. At full speed (cfg_low_speed=0) J is dp=1,dm=0 and K is dp=0,dm=1. At low speed J and K are swapped. When released (usb_oe=0), dp and dm are both 0.
- R3: Byte bits go out LSB first as NRZI. A 0 changes the line between J and K, a 1 keeps it, and the line starts from J.
- R4: After six consecutive ones an extra toggling zero is inserted. Any zero, sent or stuffed, restarts the count. Runs that cross a byte boundary are counted, and a run that ends the last byte is stuffed before the end of packet.
- R5: A 16-bit accumulator adds the increment every clock while busy and starts from zero at each packet. Each carry out advances the line by one bit. With cfg_rate_inc=0x4000 at full speed every bit lasts 4 clocks, and the first bit appears 4 clocks after the start word is accepted.
- R6: At low speed the increment is cfg_rate_inc shifted right by 3 (0x4000 gives 32 clocks per bit).
- R7: A non-start word accepted during the data phase fills the one-byte holding register. While that register is full, buf_full is 1 and wr_ready is 0. The held byte follows the current one with no gap.
- R8: When a bit is needed and no byte is held, the line shows SE0 for two bit times, then J for one bit time, then usb_oe falls.
- R9: busy is high from the clock edge that accepts a start word until the end-of-packet J bit has finished. usb_oe is never high while busy is low.
- R10: A start-flagged word accepted while busy is dropped, leaves the packet unchanged, and raises err_pulse for exactly one clock.
- R11: A word without the start flag accepted while idle is dropped and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_low_speed | input | 1 | 1 selects low speed (rate /8, J/K swapped) |
| cfg_rate_inc | input | 16 | Full-speed oscillator increment |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Block can take a word |
| wr_data | input | 9 | Bit 8 start flag, bits 7:0 byte |
| buf_full | output | 1 | Holding register occupied |
| busy | output | 1 | Packet in progress |
| err_pulse | output | 1 | One-clock pulse for a start word written while busy |
| usb_dp | output | 1 | D+ drive level |
| usb_dm | output | 1 | D- drive level |
| usb_oe | output | 1 | Pair driven |

## Verification
The assertions assume that cfg_low_speed and cfg_rate_inc change only while busy is low. They also assume the increment is nonzero and no larger than 0x4000, so a carry is never followed by an immediate second carry. The stimulus sets both configuration inputs only between packets, using 0x4000 at both speeds. Writes are placed at falling edges and held until wr_ready is seen. As a result, the back-pressure rule is the only thing that can keep a word out of the holding register.

// File: rtl/usb_ltx_pkg.sv
package usb_ltx_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10
  } line_sym_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DATA = 3'd1,
    ST_EOP2 = 3'd2,
    ST_EOPJ = 3'd3,
    ST_REL  = 3'd4
  } tx_state_t;

  localparam int STUFF_RUN = 6;

endpackage

// File: rtl/usb_ltx_nco.sv
module usb_ltx_nco #(
  parameter int ACC_W    = 16,
  parameter int LS_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             low_speed,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_eff;
  logic [ACC_W:0]   sum;

  always_comb begin
    inc_eff = low_speed ? (inc >> LS_SHIFT) : inc;
    sum     = {1'b0, acc_q} + {1'b0, inc_eff};
    tick    = run && sum[ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (run) acc_q <= sum[ACC_W-1:0];
    else acc_q <= '0;
  end

endmodule

// File: rtl/usb_ltx_hold.sv
module usb_ltx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (load) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  AST_HOLD_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) load |-> !full); // R7
  AST_HOLD_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n) pop |-> full); // R7

endmodule

// File: rtl/usb_ltx_serial.sv
module usb_ltx_serial
  import usb_ltx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_load,
  input  logic [DATA_W-1:0] start_byte,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_byte,
  output logic              pop,
  output logic              data_open,
  output logic              busy,
  output line_sym_t         sym,
  output logic              oe
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  tx_state_t         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic [RUN_W-1:0]  ones_q;
  line_sym_t         sym_q;
  logic              oe_q;

  logic      stuff_now;
  logic      need_new;
  logic      underrun;
  logic      src_bit;
  line_sym_t flipped;

  always_comb begin
    stuff_now = (ones_q == RUN_W'(STUFF_RUN));
    need_new  = (left_q == '0);
    underrun  = need_new && !hold_full && !stuff_now;
    src_bit   = need_new ? hold_byte[0] : shreg_q[0];
    flipped   = (sym_q == SYM_J) ? SYM_K : SYM_J;
    pop       = tick && (state_q == ST_DATA) && !stuff_now && need_new && hold_full;
    data_open = (state_q == ST_DATA) && !(tick && underrun);
    busy      = (state_q != ST_IDLE);
    sym       = sym_q;
    oe        = oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      ones_q  <= '0;
      sym_q   <= SYM_J;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_load) begin
            shreg_q <= start_byte;
            left_q  <= CNT_W'(DATA_W);
            ones_q  <= '0;
            sym_q   <= SYM_J;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick) begin
            oe_q <= 1'b1;
            if (stuff_now) begin
              sym_q  <= flipped;
              ones_q <= '0;
            end else if (underrun) begin
              sym_q   <= SYM_SE0;
              state_q <= ST_EOP2;
            end else begin
              if (src_bit) begin
                ones_q <= ones_q + RUN_W'(1);
              end else begin
                sym_q  <= flipped;
                ones_q <= '0;
              end
              if (need_new) begin
                shreg_q <= hold_byte >> 1;
                left_q  <= CNT_W'(DATA_W - 1);
              end else begin
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - CNT_W'(1);
              end
            end
          end
        end
        ST_EOP2: begin
          if (tick) state_q <= ST_EOPJ;
        end
        ST_EOPJ: begin
          if (tick) begin
            sym_q   <= SYM_J;
            state_q <= ST_REL;
          end
        end
        ST_REL: begin
          if (tick) begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_STUFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ones_q <= RUN_W'(STUFF_RUN)); // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable({sym_q, oe_q})); // R5

endmodule

// File: rtl/usb_line_tx.sv
module usb_line_tx
  import usb_ltx_pkg::*;
#(
  parameter int ACC_W    = 16,
  parameter int DATA_W   = 8,
  parameter int LS_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_low_speed,
  input  logic [ACC_W-1:0]  cfg_rate_inc,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W:0]   wr_data,
  output logic              buf_full,
  output logic              busy,
  output logic              err_pulse,
  output logic              usb_dp,
  output logic              usb_dm,
  output logic              usb_oe
);

  logic      tick;
  logic      hold_full;
  logic [DATA_W-1:0] hold_byte;
  logic      pop;
  logic      data_open;
  logic      eng_busy;
  line_sym_t sym;
  logic      oe;
  logic      fire;
  logic      is_start;
  logic      start_load;
  logic      hold_load;
  logic      err_q;

  always_comb begin
    wr_ready   = !hold_full;
    fire       = wr_valid && wr_ready;
    is_start   = wr_data[DATA_W];
    start_load = fire && is_start && !eng_busy;
    hold_load  = fire && !is_start && data_open;
  end

  usb_ltx_nco #(.ACC_W(ACC_W), .LS_SHIFT(LS_SHIFT)) nco_i (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .low_speed(cfg_low_speed),
    .inc(cfg_rate_inc), .tick(tick)
  );

  usb_ltx_hold #(.W(DATA_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .din(wr_data[DATA_W-1:0]),
    .pop(pop), .full(hold_full), .dout(hold_byte)
  );

  usb_ltx_serial #(.DATA_W(DATA_W)) ser_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_load(start_load),
    .start_byte(wr_data[DATA_W-1:0]), .hold_full(hold_full), .hold_byte(hold_byte),
    .pop(pop), .data_open(data_open), .busy(eng_busy), .sym(sym), .oe(oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else err_q <= fire && is_start && eng_busy;
  end

  always_comb begin
    buf_full  = hold_full;
    busy      = eng_busy;
    err_pulse = err_q;
    usb_oe    = oe;
    usb_dp    = 1'b0;
    usb_dm    = 1'b0;
    if (oe) begin
      case (sym)
        SYM_J:   {usb_dp, usb_dm} = cfg_low_speed ? 2'b01 : 2'b10;
        SYM_K:   {usb_dp, usb_dm} = cfg_low_speed ? 2'b10 : 2'b01;
        default: {usb_dp, usb_dm} = 2'b00;
      endcase
    end
  end

  AST_ERR_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) err_pulse |-> $past(busy)); // R10
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) usb_oe |-> busy); // R9
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !buf_full |-> wr_ready); // R7

endmodule

// File: tb/usb_line_tx_tb.sv
`timescale 1ns/1ps
module usb_line_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_low_speed = 1'b0;
  logic [15:0] cfg_rate_inc = 16'h4000;
  logic        wr_valid = 1'b0;
  logic [8:0]  wr_data = '0;
  logic        wr_ready, buf_full, busy, err_pulse, usb_dp, usb_dm, usb_oe;

  int checks = 0;
  int fails = 0;
  int pkts = 0;
  int P = 4;
  bit exp_bits[$];

  always #2.5 clk = ~clk;

  usb_line_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_low_speed(cfg_low_speed), .cfg_rate_inc(cfg_rate_inc),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .buf_full(buf_full),
    .busy(busy), .err_pulse(err_pulse), .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 0 SE0, 1 J, 2 K, 3 illegal
  function automatic int cls();
    if (!usb_dp && !usb_dm) return 0;
    if (usb_dp && usb_dm) return 3;
    if (cfg_low_speed) return usb_dm ? 1 : 2;
    return usb_dp ? 1 : 2;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_bits.push_back(b[i]);
  endtask

  task automatic wr(input logic [8:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_pkts(input int n);
    while (pkts < n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_packet();
    int prev = 1;
    int ones = 0;
    bit fin = 0;
    int s, s2, b, e;
    while (!fin) begin
      s = cls();
      repeat (P - 1) @(negedge clk);
      s2 = cls();
      chk("R5", "symbol held one bit period", s2, s);
      if (s == 0) begin
        chk("R4", "run of six stuffed before EOP", int'(ones == 6), 0);
        chk("R8", "all queued bits sent before EOP", exp_bits.size(), 0);
        exp_bits.delete();
        @(negedge clk);
        chk("R8", "second SE0", cls(), 0);
        repeat (P) @(negedge clk);
        chk("R8", "J after SE0", cls(), 1);
        chk("R9", "busy during EOP J", busy, 1);
        repeat (P) @(negedge clk);
        chk("R8", "pair released", usb_oe, 0);
        chk("R9", "busy cleared after J", busy, 0);
        pkts++;
        fin = 1;
      end else begin
        if (s == 3) chk("R2", "legal line state", s, 1);
        b = (s == prev) ? 1 : 0;
        if (ones == 6) begin
          chk("R4", "stuffed zero", b, 0);
          ones = 0;
        end else begin
          if (exp_bits.size() == 0) begin
            chk("R3", "bit with empty expectation", 1, 0);
          end else begin
            e = int'(exp_bits.pop_front());
            chk("R3", "decoded data bit", b, e);
          end
          ones = b ? ones + 1 : 0;
        end
        prev = s;
        @(negedge clk);
      end
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (usb_oe === 1'b1) run_packet();
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", busy, 0);
    chk("R2", "reset oe", usb_oe, 0);
    chk("R2", "reset dp/dm", {usb_dp, usb_dm}, 0);
    chk("R7", "reset buf_full", buf_full, 0);
    chk("R1", "reset ready", wr_ready, 1);
    chk("R10", "reset err", err_pulse, 0);

    // R11: unflagged word while idle
    wr(9'h055);
    repeat (10) @(negedge clk);
    chk("R11", "no packet from unflagged word (busy)", busy, 0);
    chk("R11", "no packet from unflagged word (oe)", usb_oe, 0);
    chk("R11", "unflagged word not held", buf_full, 0);

    // R1 R3 R5 R8: single sync byte, first-bit latency
    push_byte(8'h80);
    wr(9'h180);
    chk("R9", "busy after start accept", busy, 1);
    n = 0;
    while (!usb_oe) begin @(negedge clk); n++; end
    chk("R5", "clocks to first bit at full speed", n, 4);
    chk("R2", "first bit K at full speed dp", usb_dp, 0);
    chk("R2", "first bit K at full speed dm", usb_dm, 1);
    wait_pkts(1);

    // R4 R7: stream with long runs across a byte boundary
    push_byte(8'h80); push_byte(8'hF0); push_byte(8'hFF); push_byte(8'h3C);
    wr(9'h180);
    wr(9'h0F0);
    chk("R7", "buf_full after queueing", buf_full, 1);
    chk("R7", "ready low while held", wr_ready, 0);
    wr(9'h0FF);
    wr(9'h03C);
    wait_pkts(2);

    // R4: six ones ending the last byte
    push_byte(8'h80); push_byte(8'hFC);
    wr(9'h180);
    wr(9'h0FC);
    wait_pkts(3);

    // R10: start word while busy is dropped
    push_byte(8'h80); push_byte(8'h12);
    wr(9'h180);
    wr(9'h1AA);
    chk("R10", "err pulse raised", err_pulse, 1);
    chk("R10", "dropped start not held", buf_full, 0);
    @(negedge clk);
    chk("R10", "err pulse one clock", err_pulse, 0);
    wr(9'h012);
    wait_pkts(4);

    // R6 R2: low speed
    cfg_low_speed = 1'b1;
    P = 32;
    push_byte(8'h80); push_byte(8'hFF);
    wr(9'h180);
    n = 0;
    while (!usb_oe) begin @(negedge clk); n++; end
    chk("R6", "clocks to first bit at low speed", n, 32);
    chk("R2", "first bit K at low speed dp", usb_dp, 1);
    chk("R2", "first bit K at low speed dm", usb_dm, 0);
    wr(9'h0FF);
    wait_pkts(5);
    chk("R9", "idle at end", busy, 0);

    finish_run();
  end

endmodule